// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits on one clock output and lets a control source switch that output off and back on without producing a shortened pulse. The stop request is active low and may arrive at any time. It passes through a short flop chain clocked by the source clock before the gating logic acts on it. The gated output always parks low. It always resumes with a complete high phase. Once it resumes, it keeps toggling for a minimum number of cycles before another stop can take hold.

The enable that masks the clock is held in a register that loads on the falling edge of the source clock. Because it can only change while the source is low, the AND of source and enable can neither spike nor clip. A separate power-down input forces the gated output low at once, whatever the stop logic is doing. A companion output copies the source clock and is never gated. A status pin reports when the stop logic is holding the output low.

Two parameters shape the block. `SYNC_STAGES` sets the depth of the synchronizer. `MIN_RUN` sets the minimum number of gated rising edges per enabled interval. A setting with a shallow chain and a short window gives a fast off latency. A deeper window protects a domain that must not be stopped and restarted in quick succession.

Top module: `clk_stop_gate`

## Requirements
- R1: `stop_req_n` passes through `SYNC_STAGES` flops on the rising edge of `clk_src`. A level sampled at rising edge p reaches the stop decision at rising edge p+`SYNC_STAGES`. A stop decided at rising edge j leaves edge j as the last gated rising edge.
- R2: While the stop logic holds the output off, `clk_gated` stays low through both phases of `clk_src`, and `stopped` reads 1. `stopped` reads 0 at all other times.
- R3: The gating enable changes only while `clk_src` is low. Every high phase of `clk_gated` therefore spans the whole high phase of `clk_src`.
- R4: When the output is stopped and the synchronized request is inactive at a rising edge, the output restarts. Its first pulse is the full high phase that follows the next rising edge of `clk_src`.
- R5: After each restart, `clk_gated` produces at least `MIN_RUN` rising edges before a stop takes effect. A request that is present throughout yields exactly `MIN_RUN` edges.
- R6: A synchronized stop request seen during the minimum window is remembered, even if it is withdrawn. It stops the output at the first rising edge where the window is complete.
- R7: `clk_free` equals `clk_src` at all times and ignores every other input.
- R8: `force_low` is sampled on the falling edge of `clk_src`. While the sampled value is 1, `clk_gated` is low. It does not change `stopped` or the stop and restart sequence.
- R9: While `rst_n` is low, `clk_gated` is low and `stopped` is 1, whatever `clk_src` does. After release, the first rising edge with an inactive synchronized request starts the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| force_low | input | 1 | Power-down force; 1 holds the gated output low |
| clk_gated | output | 1 | Gated copy of the source clock |
| clk_free | output | 1 | Ungated copy of the source clock |
| stopped | output | 1 | 1 while the stop logic parks the output low |

## Verification
The bench builds the block with `MIN_RUN` = 6 and `SYNC_STAGES` = 3. The short window lets many stop, pend and restart episodes fit into a short run. These include a one-cycle request withdrawn inside the window and a request held across the whole window. The three-stage chain keeps the latency from request to decision long enough to tell apart from an off-by-one error in the synchronizer. Both phases of every cycle are compared with a behavioural model, so a clipped first pulse or a high park level shows up at once.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;
  typedef enum logic {
    GS_HALT = 1'b0,
    GS_RUN  = 1'b1
  } gate_state_e;
endpackage

// File: rtl/cgs_sync.sv
`timescale 1ns/1ps
// Level synchronizer for an active-low asynchronous input; idles high.
module cgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_n};
      end
    end
  endgenerate

  assign q_n = chain_q[STAGES-1];
endmodule

// File: rtl/cgs_window.sv
`timescale 1ns/1ps
// Counts running cycles since the last restart; saturates at the window end.
module cgs_window #(
  parameter int MIN_RUN = 10,
  parameter int CNT_W   = $clog2(MIN_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic running,
  output logic done
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_RUN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (running && !done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cgs_ctrl.sv
`timescale 1ns/1ps
// Stop/run decision with a pending flag for requests raised inside the window.
module cgs_ctrl
  import clk_stop_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_sync,
  input  logic win_done,
  output logic run,
  output logic restart
);
  gate_state_e state_q, state_d;
  logic        pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    restart = 1'b0;
    case (state_q)
      GS_RUN: begin
        if ((stop_sync || pend_q) && win_done) begin
          state_d = GS_HALT;
          pend_d  = 1'b0;
        end else if (stop_sync) begin
          pend_d = 1'b1;
        end
      end
      default: begin
        if (!stop_sync) begin
          state_d = GS_RUN;
          restart = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_HALT;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign run = (state_q == GS_RUN);
endmodule

// File: rtl/cgs_gate.sv
`timescale 1ns/1ps
// Enable registers load in the low phase, so the AND cannot glitch.
module cgs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic force_low,
  output logic clk_out,
  output logic halted
);
  logic run_lo_q;
  logic pd_lo_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_lo_q <= 1'b0;
      pd_lo_q  <= 1'b0;
    end else begin
      run_lo_q <= run;
      pd_lo_q  <= force_low;
    end
  end

  assign clk_out = clk & run_lo_q & ~pd_lo_q;
  assign halted  = ~run_lo_q;
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int MIN_RUN     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic stop_req_n,
  input  logic force_low,
  output logic clk_gated,
  output logic clk_free,
  output logic stopped
);
  localparam int CNT_W = $clog2(MIN_RUN + 1);

  logic stop_sync_n;
  logic run;
  logic restart;
  logic win_done;

  cgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_src),
    .rst_n (rst_n),
    .d_n   (stop_req_n),
    .q_n   (stop_sync_n)
  );

  cgs_window #(.MIN_RUN(MIN_RUN), .CNT_W(CNT_W)) u_window (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .restart (restart),
    .running (run),
    .done    (win_done)
  );

  cgs_ctrl u_ctrl (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .stop_sync (~stop_sync_n),
    .win_done  (win_done),
    .run       (run),
    .restart   (restart)
  );

  cgs_gate u_gate (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .run       (run),
    .force_low (force_low),
    .clk_out   (clk_gated),
    .halted    (stopped)
  );

  assign clk_free = clk_src;
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int MIN_RUN = 10
) (
  input logic clk_src,
  input logic rst_n,
  input logic force_low,
  input logic clk_gated,
  input logic stopped
);
  localparam int CNT_W = $clog2(MIN_RUN + 1);

  logic [CNT_W-1:0] run_len_q;

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n)                          run_len_q <= '0;
    else if (stopped)                    run_len_q <= '0;
    else if (run_len_q < CNT_W'(MIN_RUN)) run_len_q <= run_len_q + 1'b1;
  end

  // R2: a parked output is low in the source high phase
  p_park_low_r2: assert property (@(negedge clk_src) disable iff (!rst_n)
    stopped |-> !clk_gated);

  // R8: a sampled force holds the output low
  p_force_low_r8: assert property (@(negedge clk_src) disable iff (!rst_n)
    $past(force_low) |-> !clk_gated);

  // R3: running and unforced means a full high phase
  p_full_high_r3: assert property (@(negedge clk_src) disable iff (!rst_n)
    (!stopped && !$past(force_low)) |-> clk_gated);

  // R5: each enabled interval lasts at least MIN_RUN cycles
  p_min_run_r5: assert property (@(negedge clk_src) disable iff (!rst_n)
    $rose(stopped) |-> (run_len_q >= CNT_W'(MIN_RUN)));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.MIN_RUN(MIN_RUN)) chk_i (
  .clk_src   (clk_src),
  .rst_n     (rst_n),
  .force_low (force_low),
  .clk_gated (clk_gated),
  .stopped   (stopped)
);

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ns/1ps
module clk_stop_gate_tb_top;
  localparam int MIN_RUN = 6;
  localparam int SYNC    = 3;

  logic clk_src = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic force_low = 1'b0;
  logic clk_gated, clk_free, stopped;

  int n_cmp = 0;
  int n_bad = 0;
  int edge_cnt = 0;
  bit done = 1'b0;
  string tag = "R9";

  always #2.5 clk_src = ~clk_src;

  clk_stop_gate #(.MIN_RUN(MIN_RUN), .SYNC_STAGES(SYNC)) dut_i (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .stop_req_n (stop_req_n),
    .force_low  (force_low),
    .clk_gated  (clk_gated),
    .clk_free   (clk_free),
    .stopped    (stopped)
  );

  // Behavioural reference model
  logic sync_q[$];
  bit   m_run, m_pend, m_gate_run, m_gate_pd;
  int   m_len;

  initial for (int i = 0; i < SYNC; i++) sync_q.push_back(1'b1);

  always @(posedge clk_src or negedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      sync_q.delete();
      for (int i = 0; i < SYNC; i++) sync_q.push_back(1'b1);
      m_run = 0; m_pend = 0; m_len = 0; m_gate_run = 0; m_gate_pd = 0;
    end else if (clk_src) begin
      bit seen;
      seen = !sync_q[SYNC-1];
      sync_q.push_front(stop_req_n);
      void'(sync_q.pop_back());
      if (m_run) begin
        if ((seen || m_pend) && m_len >= MIN_RUN - 1) begin
          m_run = 0; m_pend = 0;
        end else begin
          if (seen) m_pend = 1;
          m_len++;
        end
      end else if (!seen) begin
        m_run = 1; m_len = 0;
      end
    end else begin
      m_gate_run = m_run;
      m_gate_pd  = force_low;
    end
  end

  always @(posedge clk_gated) edge_cnt++;

  task automatic cmp(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk_src) begin
    #1.25;
    cmp(clk_gated, m_gate_run && !m_gate_pd, "clk_gated high phase");
    cmp(stopped, !m_gate_run, "stopped");
    cmp(clk_free, 1'b1, "clk_free R7");
  end

  always @(negedge clk_src) begin
    #1.25;
    cmp(clk_gated, 1'b0, "clk_gated low phase");
    cmp(stopped, !m_gate_run, "stopped");
    cmp(clk_free, 1'b0, "clk_free R7");
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_src);
    #0.5;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    step(4);
    tag = "R9";
    rst_n = 1'b1;
    tag = "R3 R7 R9";
    step(20);
    // stop held, then released
    tag = "R1 R2";
    stop_req_n = 1'b0;
    step(18);
    tag = "R4 R3";
    stop_req_n = 1'b1;
    step(4);
    // one-cycle request inside the window, withdrawn
    tag = "R6 R5";
    stop_req_n = 1'b0;
    step(1);
    stop_req_n = 1'b1;
    step(25);
    // request held throughout a fresh window
    tag = "R5 R1";
    stop_req_n = 1'b0;
    step(15);
    stop_req_n = 1'b1;
    step(1);
    edge_cnt = 0;
    stop_req_n = 1'b0;
    step(40);
    tag = "R5";
    n_cmp++;
    if (edge_cnt != MIN_RUN) begin
      n_bad++;
      $display("FAIL R5 edges in held window: actual %0d expected %0d", edge_cnt, MIN_RUN);
    end
    // force while stopped, then while running
    tag = "R8 R2";
    force_low = 1'b1;
    step(5);
    stop_req_n = 1'b1;
    tag = "R8";
    step(12);
    force_low = 1'b0;
    step(6);
    force_low = 1'b1;
    step(3);
    force_low = 1'b0;
    step(10);
    // asynchronous reset in mid-run
    tag = "R9";
    #0.4;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    tag = "R9 R4";
    step(12);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule